// File: doc/BRIEF.md
# Variable-Length Fetch Aligner

This block is the front end of a fast 8-bit processor whose instructions occupy one, two or three bytes. It reads program memory one aligned 32-bit word at a time and keeps the bytes in a small shift queue. Every cycle it shows the decoder a 4-byte window that starts at the current instruction. Because an instruction is never longer than three bytes, the window always holds a whole instruction once enough bytes are present. Fetch addresses need not be word aligned, so an instruction that spans two memory words is joined from both of them.

Within the same cycle, the decoder looks at the window and returns the length of the head instruction. When the window is valid and the length is non-zero, the queue drops that many bytes on the next clock edge and the program counter moves forward by the same amount. A length of zero holds everything in place. A redirect loads a new target address, empties the queue and starts reading again at the word that holds the target. Bytes of that first word that come before the target are discarded. A read that is still in flight when the redirect arrives is thrown away when its data returns.

Top module: `fetch_aligner`

## Requirements
- R1: During synchronous active-high reset the queue is emptied and `pc` takes the parameter `RESET_ADDR`. In the first cycle after reset `win_valid` is 0, and `mem_req` is 1 with `mem_addr` equal to `RESET_ADDR` with its two low bits cleared.
- R2: Every read address has its two low bits at zero. In the returned word, byte k of `mem_rdata` (bits 8k+7 down to 8k) is the byte at address `mem_addr`+k.
- R3: At most one read is outstanding. `mem_req` rises only when no read is in flight and at least 4 of the QDEPTH queue slots are free, so the queue never overflows.
- R4: Byte k of `win_data` (bits 8k+7 down to 8k) is the program byte at `pc`+k, for every byte the window is valid for.
- R5: `win_valid` is 1 exactly when the queue holds at least 3 bytes, or when `dec_len` is non-zero and the queue holds at least `dec_len` bytes.
- R6: When `win_valid` is 1, `dec_len` is non-zero and no redirect is present, the window advances by `dec_len` bytes on the next edge and `pc` increases by `dec_len`.
- R7: A `dec_len` of 0 with no redirect holds `pc` and the head byte of the window.
- R8: An instruction that spans two memory words is shown complete and in order in the window.
- R9: A redirect loads `pc` with `redir_addr` and empties the queue. The next read goes to the word holding the target. Bytes of that word below the target's offset in the word (`redir_addr` bits 1:0) are discarded.
- R10: A read still outstanding when a redirect is accepted is discarded on return and never enters the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | output | 1 | Read request, one cycle per read |
| mem_addr | output | AW | Word-aligned read address |
| mem_rvalid | input | 1 | Read data valid, at least one cycle after the request |
| mem_rdata | input | 32 | Read data, little-endian byte order |
| win_data | output | 32 | Instruction window; byte 0 is at `pc` |
| win_valid | output | 1 | Window holds a complete head instruction |
| dec_len | input | 2 | Decoder's head-instruction length, 0 means stall |
| redir_valid | input | 1 | Redirect to a new address |
| redir_addr | input | AW | Redirect target |
| pc | output | AW | Address of the head byte |

## Verification
A wrong byte count in the queue shows up within one cycle. Either `win_valid` disagrees with the head length, or the window carries bytes that do not belong at `pc`. A wrong discard offset after a redirect makes the very first window at the target start at the wrong byte, in the cycle after the first word arrives. Stale data that should have been dropped shows up as foreign bytes in the first windows after the redirect. A slip in the read address shows up as mismatched window bytes once the affected word reaches the head, a few cycles after the request.

// File: rtl/fa_pkg.sv
package fa_pkg;

  typedef logic [7:0] byte_t;
  typedef logic [1:0] len_t;

  // number of bytes of a fetched word that survive a leading discard
  function automatic int kept_bytes(input logic [1:0] skip);
    return 4 - int'(skip);
  endfunction

  // a head instruction is presentable when three bytes sit in the queue,
  // or when the queue already covers the length the decoder reports
  function automatic logic head_ready(input int count, input len_t len);
    return (count >= 3) || ((len != 2'd0) && (count >= int'(len)));
  endfunction

  // occupancy after a pop and an optional push
  function automatic int next_fill(input int count, input int pop,
                                   input logic push, input logic [1:0] skip);
    return count - pop + (push ? kept_bytes(skip) : 0);
  endfunction

endpackage

// File: rtl/fa_queue.sv
module fa_queue
  import fa_pkg::*;
#(
  parameter int QDEPTH = 8,
  localparam int CW = $clog2(QDEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  len_t          pop,
  input  logic          push_en,
  input  logic [31:0]   push_word,
  input  logic [1:0]    push_skip,
  output logic [31:0]   window,
  output logic [CW-1:0] fill
);

  byte_t         slot_q [QDEPTH];
  byte_t         slot_d [QDEPTH];
  logic [CW-1:0] fill_d;

  always_comb begin
    int base;
    int src;
    int j;
    base = int'(fill) - int'(pop);
    for (int i = 0; i < QDEPTH; i++) begin
      src = i + int'(pop);
      slot_d[i] = '0;
      if (src < int'(fill) && src < QDEPTH) slot_d[i] = slot_q[src];
      j = i - base + int'(push_skip);
      if (push_en && j >= int'(push_skip) && j <= 3) slot_d[i] = push_word[8*j +: 8];
      if (flush) slot_d[i] = '0;
    end
    fill_d = flush ? '0 : CW'(next_fill(int'(fill), int'(pop), push_en, push_skip));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill <= '0;
      for (int i = 0; i < QDEPTH; i++) slot_q[i] <= '0;
    end else begin
      fill   <= fill_d;
      slot_q <= slot_d;
    end
  end

  generate
    for (genvar k = 0; k < 4; k++) begin : g_win
      assign window[8*k +: 8] = slot_q[k];
    end
  endgenerate

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push_en |-> (int'(fill) - int'(pop) + kept_bytes(push_skip)) <= QDEPTH); // R3
  AST_POP_COVERED: assert property (@(posedge clk) disable iff (rst)
    int'(pop) <= int'(fill)); // R6

endmodule

// File: rtl/fa_fetch.sv
module fa_fetch #(
  parameter int AW = 16,
  parameter int QDEPTH = 8,
  parameter logic [AW-1:0] RESET_ADDR = '0,
  localparam int CW = $clog2(QDEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          redir,
  input  logic [AW-1:0] redir_addr,
  input  logic [CW-1:0] fill,
  input  logic          mem_rvalid,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          push_en,
  output logic [1:0]    push_skip,
  output logic          flush
);

  logic [AW-1:0] word_addr;
  logic          in_flight;
  logic          drop_next;
  logic [1:0]    skip_q;

  assign mem_req   = !rst && !in_flight && !redir && (int'(fill) <= QDEPTH - 4);
  assign mem_addr  = word_addr;
  assign push_en   = mem_rvalid && in_flight && !drop_next && !redir;
  assign push_skip = skip_q;
  assign flush     = redir;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_addr <= {RESET_ADDR[AW-1:2], 2'b00};
      skip_q    <= RESET_ADDR[1:0];
      in_flight <= 1'b0;
      drop_next <= 1'b0;
    end else begin
      if (mem_req) begin
        in_flight <= 1'b1;
        word_addr <= word_addr + AW'(4);
      end
      if (mem_rvalid) begin
        in_flight <= 1'b0;
        drop_next <= 1'b0;
      end
      if (push_en) skip_q <= 2'd0;
      if (redir) begin
        word_addr <= {redir_addr[AW-1:2], 2'b00};
        skip_q    <= redir_addr[1:0];
        drop_next <= in_flight && !mem_rvalid;
      end
    end
  end

  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[1:0] == 2'b00)); // R2
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req); // R3
  AST_REDIR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    redir |=> (fill == '0)); // R9
  AST_STALE_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (redir && in_flight && !mem_rvalid) |=> !push_en); // R10

endmodule

// File: rtl/fetch_aligner.sv
module fetch_aligner
  import fa_pkg::*;
#(
  parameter int AW = 16,
  parameter int QDEPTH = 8,
  parameter logic [AW-1:0] RESET_ADDR = 16'h0102,
  localparam int CW = $clog2(QDEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic [31:0]   win_data,
  output logic          win_valid,
  input  logic [1:0]    dec_len,
  input  logic          redir_valid,
  input  logic [AW-1:0] redir_addr,
  output logic [AW-1:0] pc
);

  logic [CW-1:0] fill;
  logic          push_en;
  logic [1:0]    push_skip;
  logic          flush;
  logic          consume;
  len_t          pop;

  assign win_valid = head_ready(int'(fill), dec_len);
  assign consume   = win_valid && (dec_len != 2'd0) && !redir_valid;
  assign pop       = consume ? dec_len : 2'd0;

  fa_fetch #(.AW(AW), .QDEPTH(QDEPTH), .RESET_ADDR(RESET_ADDR)) u_fetch (
    .clk       (clk),
    .rst       (rst),
    .redir     (redir_valid),
    .redir_addr(redir_addr),
    .fill      (fill),
    .mem_rvalid(mem_rvalid),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .push_en   (push_en),
    .push_skip (push_skip),
    .flush     (flush)
  );

  fa_queue #(.QDEPTH(QDEPTH)) u_queue (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .pop      (pop),
    .push_en  (push_en),
    .push_word(mem_rdata),
    .push_skip(push_skip),
    .window   (win_data),
    .fill     (fill)
  );

  always_ff @(posedge clk) begin
    if (rst)              pc <= RESET_ADDR;
    else if (redir_valid) pc <= redir_addr;
    else if (consume)     pc <= pc + AW'(dec_len);
  end

  AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    consume |=> (pc == $past(pc) + AW'($past(dec_len)))); // R6
  AST_STALL_PC: assert property (@(posedge clk) disable iff (rst)
    (dec_len == 2'd0 && !redir_valid) |=> $stable(pc)); // R7
  AST_STALL_HEAD: assert property (@(posedge clk) disable iff (rst)
    (win_valid && dec_len == 2'd0 && !redir_valid) |=> $stable(win_data[7:0])); // R7
  AST_VALID_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> (fill != '0)); // R5

endmodule

// File: tb/sim_fetch_aligner.sv
`timescale 1ns/1ps
module sim_fetch_aligner;

  logic        clk = 1'b0;
  logic        rst;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic [31:0] win_data;
  logic        win_valid;
  logic [1:0]  dec_len;
  logic        redir_valid;
  logic [15:0] redir_addr;
  logic [15:0] pc;

  int checks = 0;
  int errors = 0;
  int lat = 1;
  int cyc = 0;
  int mcnt = 0;
  logic [15:0] saved_addr;
  logic [15:0] last_addr;
  logic [15:0] exp_pc;

  always #4 clk = ~clk;

  fetch_aligner #(.AW(16), .QDEPTH(8), .RESET_ADDR(16'h0102)) u0 (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .win_data(win_data),
    .win_valid(win_valid), .dec_len(dec_len), .redir_valid(redir_valid),
    .redir_addr(redir_addr), .pc(pc)
  );

  function automatic logic [7:0] mb(input logic [15:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ 8'h96;
  endfunction

  function automatic logic [31:0] mw(input logic [15:0] a);
    return {mb(a + 16'd3), mb(a + 16'd2), mb(a + 16'd1), mb(a)};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: one word per request, returned after lat cycles
  always @(posedge clk) begin
    if (rst) begin
      mcnt <= 0;
      mem_rvalid <= 1'b0;
      mem_rdata <= '0;
    end else begin
      mem_rvalid <= 1'b0;
      if (mcnt == 1) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mw(saved_addr);
        last_addr  <= saved_addr;
        mcnt <= 0;
      end else if (mcnt > 1) mcnt <= mcnt - 1;
      if (mem_req) begin
        chk(mcnt == 0 && !mem_rvalid, "R3 request while read in flight", 32'(mcnt), 32'd0);
        chk(mem_addr[1:0] == 2'b00, "R2 aligned address", 32'(mem_addr), 32'(mem_addr & 16'hFFFC));
        saved_addr <= mem_addr;
        mcnt <= lat;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // {redirect, length, target}
  localparam int NV = 20;
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 2'd3, 16'h0000}, {1'b0, 2'd1, 16'h0000}, {1'b0, 2'd2, 16'h0000},
    {1'b0, 2'd3, 16'h0000}, {1'b0, 2'd0, 16'h0000}, {1'b0, 2'd3, 16'h0000},
    {1'b0, 2'd3, 16'h0000}, {1'b0, 2'd2, 16'h0000}, {1'b1, 2'd0, 16'h0407},
    {1'b0, 2'd2, 16'h0000}, {1'b0, 2'd3, 16'h0000}, {1'b0, 2'd1, 16'h0000},
    {1'b0, 2'd0, 16'h0000}, {1'b0, 2'd3, 16'h0000}, {1'b1, 2'd0, 16'h1001},
    {1'b0, 2'd3, 16'h0000}, {1'b0, 2'd2, 16'h0000}, {1'b0, 2'd2, 16'h0000},
    {1'b0, 2'd1, 16'h0000}, {1'b1, 2'd0, 16'h0102}
  };

  // one cycle: drive at the falling edge, read back after settling
  task automatic cycle(input logic r, input logic [1:0] l, input logic [15:0] t,
                       input string tag, output logic took);
    @(negedge clk);
    redir_valid = r;
    redir_addr  = t;
    dec_len     = l;
    #1;
    chk(pc == exp_pc, "R6 pc tracks head", 32'(pc), 32'(exp_pc));
    took = 1'b0;
    if (r) begin
      exp_pc = t;
      took = 1'b1;
    end else if (win_valid && l != 2'd0) begin
      for (int k = 0; k < int'(l); k++)
        chk(win_data[8*k +: 8] == mb(exp_pc + 16'(k)), tag,
            32'(win_data[8*k +: 8]), 32'(mb(exp_pc + 16'(k))));
      exp_pc = exp_pc + 16'(l);
      took = 1'b1;
    end
  endtask

  task automatic run_entry(input logic [18:0] v);
    logic took;
    int tries;
    if (!v[18] && v[17:16] == 2'd0) begin
      for (int s = 0; s < 3; s++) begin
        cycle(1'b0, 2'd0, 16'h0, "R7", took);
        if (win_valid)
          chk(win_data[7:0] == mb(exp_pc), "R7 head held during stall",
              32'(win_data[7:0]), 32'(mb(exp_pc)));
      end
    end else begin
      took = 1'b0;
      tries = 0;
      while (!took && tries < 40) begin
        cycle(v[18], v[17:16], v[15:0], "R4 R8 window bytes", took);
        tries++;
      end
      chk(took, "R5 window never became valid", 32'(took), 32'd1);
    end
  endtask

  initial begin
    logic took;
    logic seen;
    rst = 1'b1;
    dec_len = 2'd0;
    redir_valid = 1'b0;
    redir_addr = '0;
    exp_pc = 16'h0102;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    dec_len = 2'd1;
    #1;
    // R1 reset state
    chk(win_valid == 1'b0, "R1 window empty after reset", 32'(win_valid), 32'd0);
    chk(pc == 16'h0102, "R1 pc at reset address", 32'(pc), 32'h0102);
    chk(mem_req == 1'b1, "R1 first request", 32'(mem_req), 32'd1);
    chk(mem_addr == 16'h0100, "R1 first address", 32'(mem_addr), 32'h0100);

    // table walk, two memory latencies
    for (int p = 0; p < 2; p++) begin
      lat = p + 1;
      for (int n = 0; n < NV; n++) run_entry(VEC[n]);
    end

    // R5: one byte present after redirect to offset 3
    for (int s = 0; s < 12; s++) cycle(1'b0, 2'd0, 16'h0, "R7", took);
    cycle(1'b1, 2'd0, 16'h2003, "R9", took);
    seen = 1'b0;
    for (int s = 0; s < 20 && !seen; s++) begin
      @(negedge clk);
      redir_valid = 1'b0;
      dec_len = 2'd0;
      #1;
      seen = mem_rvalid && (last_addr == 16'h2000);
    end
    chk(seen, "R9 read of target word", 32'(last_addr), 32'h2000);
    @(negedge clk);
    dec_len = 2'd2;
    #1;
    chk(win_valid == 1'b0, "R5 one byte does not cover length 2", 32'(win_valid), 32'd0);
    dec_len = 2'd1;
    #1;
    chk(win_valid == 1'b1, "R5 one byte covers length 1", 32'(win_valid), 32'd1);
    chk(win_data[7:0] == mb(16'h2003), "R9 leading bytes discarded",
        32'(win_data[7:0]), 32'(mb(16'h2003)));
    chk(pc == 16'h2003, "R9 pc loaded", 32'(pc), 32'h2003);
    dec_len = 2'd0;

    // R10: redirect while a read is outstanding
    lat = 2;
    for (int s = 0; s < 12; s++) cycle(1'b0, 2'd0, 16'h0, "R7", took);
    cycle(1'b1, 2'd0, 16'h0500, "R9", took);
    @(negedge clk);
    redir_valid = 1'b0;
    #1;
    chk(mem_req == 1'b1, "R9 request after redirect", 32'(mem_req), 32'd1);
    chk(mem_addr == 16'h0500, "R9 target word address", 32'(mem_addr), 32'h0500);
    cycle(1'b1, 2'd0, 16'h3001, "R10", took);
    for (int s = 0; s < 6; s++) run_entry({1'b0, 2'd2, 16'h0000});
    for (int s = 0; s < 3; s++) run_entry({1'b0, 2'd3, 16'h0000});
    cycle(1'b0, 2'd0, 16'h0, "R10", took);
    chk(pc == 16'h3001 + 16'd21, "R10 pc after stale drop", 32'(pc), 32'(16'h3001 + 16'd21));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule